// File: doc/BRIEF.md
# Input Change Interrupt Controller

This block watches a general-purpose port whose bits can each be configured as inputs or outputs. Every change seen on an input bit is recorded in a sticky status vector. An active-low alert line tells the host that an interrupt-enabled input has changed. Incoming pin levels first pass through a synchronizer. An edge detector compares each synchronized sample with the previous one. The status/alert core then sets status bits, decides whether to pull the alert line low, and handles the two ways of releasing it.

The host bus layer is not part of this block and appears only as two single-cycle strobes. One strobe marks a read of the status vector. That read returns the current contents and clears them, and it also releases the alert. The other strobe marks a completed alert-response-address reply. That reply releases the alert and leaves the status vector unchanged. Status capture always runs. The global enable and the per-bit mask affect only the alert.

Top module: `gpio_change_irq`

## Requirements
- R1: A level change on a pin whose direction bit is 1 (input) sets the matching `status_o` bit, whatever the mask and enable settings. The bit is visible on the third rising edge after the pin changes: two synchronizer stages plus one capture stage.
- R2: A change on a pin whose direction bit is 0 (output) never sets its status bit.
- R3: Several changes on the same input between two status reads leave that bit set once. The changes are not counted.
- R4: While `stat_rd_i` is high for one cycle, `status_o` shows the contents being read. On the next cycle the contents are cleared to zero.
- R5: A change that is captured on the same edge as a status read remains set in `status_o` after the read.
- R6: `alert_n_o` goes low only on a change of an input whose mask bit is 1, while `irq_en_i` is 1. Setting the enable or a mask bit later, while status bits are already set, does not pull the alert low.
- R7: An `ara_ack_i` pulse releases `alert_n_o` to 1 and leaves `status_o` unchanged.
- R8: A `stat_rd_i` pulse releases `alert_n_o` to 1.
- R9: After a release, `alert_n_o` stays at 1 until a new enabled change occurs. If that change coincides with a release strobe, the alert stays low.
- R10: After reset, `status_o` is all zero and `alert_n_o` is 1. Direction, mask and enable inputs are assumed zero at reset, so interrupts start disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | WIDTH | Raw port pin levels |
| dir_in_i | input | WIDTH | Direction per bit, 1 = input |
| irq_mask_i | input | WIDTH | Interrupt enable per bit, 1 = enabled |
| irq_en_i | input | 1 | Global interrupt enable |
| stat_rd_i | input | 1 | Single-cycle status read strobe |
| ara_ack_i | input | 1 | Single-cycle alert response completion strobe |
| status_o | output | WIDTH | Sticky input-change status |
| alert_n_o | output | 1 | Active-low alert |

## Verification
A stale previous-sample register in the edge detector appears as a missing or spurious status bit exactly three cycles after a pin change. A corrupted status register shows at once, both in the value returned during a read strobe and in the zero that must follow it. An alert flag that does not clear, or that sets again on its own, shows on `alert_n_o` in the cycle after a release strobe. It shows again during quiet periods in which no enabled change arrives. The coincident read-and-change case shows, in the cycle after the strobe, whether a merge-priority mistake drops an event.

// File: rtl/gci_pkg.sv
package gci_pkg;
    // Default port width and synchronizer depth for the controller.
    localparam int unsigned GCI_WIDTH       = 8;
    localparam int unsigned GCI_SYNC_STAGES = 2;
endpackage

// File: rtl/gci_sync.sv
module gci_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign sync_o = stage_q[LAST];
endmodule

// File: rtl/gci_edge_detect.sv
module gci_edge_detect #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sample_i,
    input  logic [WIDTH-1:0] dir_in_i,
    output logic [WIDTH-1:0] change_o
);
    logic [WIDTH-1:0] prev_d, prev_q;

    // The previous sample tracks every bit, so a direction flip cannot fake an edge.
    always_comb begin
        prev_d   = sample_i;
        change_o = (sample_i ^ prev_q) & dir_in_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/gci_status_alert.sv
module gci_status_alert #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] change_i,
    input  logic [WIDTH-1:0] mask_i,
    input  logic             irq_en_i,
    input  logic             stat_rd_i,
    input  logic             ara_ack_i,
    output logic [WIDTH-1:0] status_o,
    output logic             alert_o
);
    typedef struct packed {
        logic [WIDTH-1:0] status;
        logic             alert;
    } core_t;

    core_t core_d, core_q;
    logic  trigger;
    logic  release_req;

    always_comb begin
        trigger     = irq_en_i & (|(change_i & mask_i));
        release_req = stat_rd_i | ara_ack_i;
        core_d      = core_q;
        // A read clears the old contents, and new changes are merged in after the clear.
        core_d.status = (stat_rd_i ? '0 : core_q.status) | change_i;
        if (trigger) begin
            core_d.alert = 1'b1;
        end else if (release_req) begin
            core_d.alert = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign status_o = core_q.status;
    assign alert_o  = core_q.alert;
endmodule

// File: rtl/gpio_change_irq.sv
module gpio_change_irq
    import gci_pkg::*;
#(
    parameter int unsigned WIDTH       = GCI_WIDTH,
    parameter int unsigned SYNC_STAGES = GCI_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    input  logic [WIDTH-1:0] dir_in_i,
    input  logic [WIDTH-1:0] irq_mask_i,
    input  logic             irq_en_i,
    input  logic             stat_rd_i,
    input  logic             ara_ack_i,
    output logic [WIDTH-1:0] status_o,
    output logic             alert_n_o
);
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] edge_chg;
    logic             alert_hi;

    gci_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    gci_edge_detect #(.WIDTH(WIDTH)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (pin_sync),
        .dir_in_i (dir_in_i),
        .change_o (edge_chg)
    );

    gci_status_alert #(.WIDTH(WIDTH)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .change_i  (edge_chg),
        .mask_i    (irq_mask_i),
        .irq_en_i  (irq_en_i),
        .stat_rd_i (stat_rd_i),
        .ara_ack_i (ara_ack_i),
        .status_o  (status_o),
        .alert_o   (alert_hi)
    );

    assign alert_n_o = ~alert_hi;
endmodule

// File: rtl/gci_checker.sv
module gci_checker #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] chg,
    input logic [WIDTH-1:0] mask,
    input logic             irq_en,
    input logic             stat_rd,
    input logic             ara_ack,
    input logic [WIDTH-1:0] status,
    input logic             alert_n
);
    logic hit;
    assign hit = irq_en && (|(chg & mask));

    // R1, R3: a detected change leaves its bit set
    assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|chg) |=> ((status & $past(chg)) == $past(chg)));

    // R4: a read with no coincident change empties the status
    assert_read_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && (chg == '0)) |=> (status == '0));

    // R5: a change coincident with a read survives it
    assert_keep_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (status == $past(chg)));

    // R6: alert only falls on an enabled change
    assert_alert_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alert_n) |-> $past(hit));

    // R7: alert response leaves the status contents in place
    assert_ara_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ara_ack && !stat_rd) |=> (status == ($past(status) | $past(chg))));

    // R8: either release strobe raises the alert line
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_rd || ara_ack) && !hit) |=> alert_n);

    // R9: a released alert stays released without a new enabled change
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_n && !hit) |=> alert_n);
endmodule

bind gpio_change_irq gci_checker #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .chg     (edge_chg),
    .mask    (irq_mask_i),
    .irq_en  (irq_en_i),
    .stat_rd (stat_rd_i),
    .ara_ack (ara_ack_i),
    .status  (status_o),
    .alert_n (alert_n_o)
);

// File: tb/tb_gpio_change_irq.sv
module tb_gpio_change_irq;
    localparam int unsigned W = 8;
    localparam int NVEC = 7;
    // fields: dir, mask, en, pin, expected status, expected alert_n
    localparam logic [33:0] VEC [NVEC] = '{
        {8'hFF, 8'h00, 1'b1, 8'h01, 8'h01, 1'b1},
        {8'hFF, 8'hFF, 1'b0, 8'h03, 8'h02, 1'b1},
        {8'hFF, 8'h02, 1'b1, 8'h01, 8'h02, 1'b0},
        {8'h0F, 8'hFF, 1'b1, 8'hF1, 8'h00, 1'b1},
        {8'hF0, 8'hF0, 1'b1, 8'h00, 8'hF0, 1'b0},
        {8'hFF, 8'h80, 1'b1, 8'h81, 8'h81, 1'b0},
        {8'hFF, 8'h7E, 1'b1, 8'h80, 8'h01, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pin = '0, dir = '0, mask = '0;
    logic         en = 1'b0, rd = 1'b0, ara = 1'b0;
    logic [W-1:0] status;
    logic         alert_n;
    int           checks = 0, errors = 0;
    bit           done = 1'b0;

    always #4 clk = ~clk;

    gpio_change_irq dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .dir_in_i(dir),
        .irq_mask_i(mask), .irq_en_i(en), .stat_rd_i(rd), .ara_ack_i(ara),
        .status_o(status), .alert_n_o(alert_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_pulse(input logic [W-1:0] exp_stat, input string req);
        rd = 1'b1;
        check(req, status, exp_stat);
        @(negedge clk);
        rd = 1'b0;
        check("R4 cleared", status, 0);
        check("R8 released", alert_n, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 status", status, 0);
        check("R10 alert_n", alert_n, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R6 R4: vector table
        for (int v = 0; v < NVEC; v++) begin
            dir  = VEC[v][33:26];
            mask = VEC[v][25:18];
            en   = VEC[v][17];
            pin  = VEC[v][16:9];
            settle(3);
            check($sformatf("R1/R2 status vec %0d", v), status, VEC[v][8:1]);
            check($sformatf("R6 alert_n vec %0d", v), alert_n, VEC[v][0]);
            read_pulse(VEC[v][8:1], "R4 read value");
        end

        // R3: repeated toggles set the bit once
        dir = 8'hFF; mask = 8'hFF; en = 1'b0;
        for (int k = 0; k < 3; k++) begin
            pin[2] = ~pin[2];
            @(negedge clk);
        end
        settle(3);
        check("R3 single bit", status, 8'h04);
        read_pulse(8'h04, "R3 read value");

        // R7, R9: alert response keeps status, alert held until new change
        en = 1'b1;
        pin[3] = ~pin[3];
        settle(3);
        check("R6 alert low", alert_n, 0);
        ara = 1'b1;
        @(negedge clk);
        ara = 1'b0;
        check("R7 alert released", alert_n, 1);
        check("R7 status kept", status, 8'h08);
        settle(10);
        check("R9 held released", alert_n, 1);
        check("R7 status still kept", status, 8'h08);
        pin[3] = ~pin[3];
        settle(3);
        check("R9 new change alerts", alert_n, 0);
        read_pulse(8'h08, "R8 read value");

        // R6: enabling later does not raise the alert for old status
        en = 1'b0;
        pin[4] = ~pin[4];
        settle(3);
        check("R1 masked capture", status, 8'h10);
        check("R6 disabled alert", alert_n, 1);
        en = 1'b1;
        settle(3);
        check("R6 late enable", alert_n, 1);
        read_pulse(8'h10, "R4 read value late");

        // R5: change captured on the read edge is kept
        pin[0] = ~pin[0];
        settle(3);
        check("R6 alert before read", alert_n, 0);
        pin[5] = ~pin[5];
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rd = 1'b1;
        check("R4 read value coincident", status, 8'h01);
        @(negedge clk);
        rd = 1'b0;
        check("R5 coincident kept", status, 8'h20);
        check("R9 coincident trigger wins", alert_n, 0);
        read_pulse(8'h20, "R5 read value");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule